// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block is the tag and replacement directory of a cache. Three parameters fix its geometry: the total capacity in bytes, the line size in bytes and the number of ways. From these it works out how many sets it has, how many address bits select a byte in a line, how many select a set, and how many form the stored tag. One parameter set covers direct-mapped (a single way), ordinary N-way, and fully associative (a single set with no index bits) configurations. The data array, refills from the next level and write policy belong to other blocks.

Each accepted request carries a byte address. The directory drops the byte-in-line bits, uses the set bits to select a set, and compares the request tag against every way of that set at once. One cycle later it reports hit or miss, the way that hit or was filled, and the tag of any line that was pushed out. On a miss it installs the new tag. It uses the lowest-numbered empty way if there is one, and otherwise the way used least recently, as tracked by per-line timestamps from a shared clock. Running totals of hits and misses are kept, and a synchronous flush clears every line and both totals.

Top module: `setassoc_tagdir`

## Requirements
- R1: Sets = CACHE_BYTES / (LINE_BYTES × WAYS). The lowest log2(LINE_BYTES) address bits are the byte offset and the next log2(sets) bits are the set index. All higher bits form the tag, and rspEvictTag reports that tag value (address shifted right by offset width plus index width).
- R2: A request hits only when a valid way of its set holds an equal tag. Two addresses in the same line give the same result, whatever their offset bits.
- R3: A miss into a set that has an empty way fills the lowest-numbered empty way, reports that way on rspWay, and drives rspEvictValid low.
- R4: A miss into a full set replaces the way whose last hit or fill is oldest. It reports that way and drives rspEvictValid high with the old tag. A hit refreshes the age of the line it hit.
- R5: With WAYS = 1 there is no replacement choice. Alternating two addresses exactly CACHE_BYTES apart misses on every request, and from the second request on, each miss evicts the other address's tag.
- R6: With WAYS = 2 the same alternating pattern misses only on its first two requests and hits on every later one.
- R7: With a single set (WAYS × LINE_BYTES = CACHE_BYTES) any line may use any way. The first WAYS distinct lines fill ways 0, 1, 2 … in order with no eviction.
- R8: reqReady is high except while flush is high. A request is accepted on a clock edge where reqValid and reqReady are both high. rspValid is high for exactly the one cycle after each accepted request.
- R9: hitCount increases by one for each accepted request that hits, and missCount by one for each that misses.
- R10: A high flush clears every line and both counters at the next edge. A request presented while flush is high is not accepted, and a line held before the flush misses afterwards without eviction.
- R11: After reset, rspValid is low, both counters are zero and every line is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all lines and counters |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted |
| reqAddr | input | ADDR_W | Byte address of the request |
| rspValid | output | 1 | Response strobe, one cycle after acceptance |
| rspHit | output | 1 | Request hit |
| rspWay | output | wayWidth(WAYS) | Way that hit or was filled |
| rspEvictValid | output | 1 | A valid line was replaced |
| rspEvictTag | output | tag width | Tag of the replaced line |
| hitCount | output | CNT_W | Hits since reset or flush |
| missCount | output | CNT_W | Misses since reset or flush |

## Verification
Three copies with the same capacity and line size (one way, two ways, and one set) receive the same request stream, so each pattern separates the geometries. Two addresses one capacity apart thrash the direct-mapped copy but settle into hits with two ways. Two addresses in one line with different offset bits must both hit, which shows the offset plays no part. A three-tag sequence in one set, with a hit in the middle, shows that the replacement order follows last use and not fill order. Filling all ways of the single-set copy shows that ways are taken in order without eviction and that the oldest line goes first once the set is full.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  typedef struct packed {
    logic lookup;  // accepted request: compare, update, respond
    logic clear;   // drop every line and zero the totals
  } dirStrobe_t;

  function automatic int tagWidth(int addrW, int cacheB, int lineB, int ways);
    return addrW - $clog2(lineB) - $clog2(cacheB / (lineB * ways));
  endfunction

  function automatic int wayWidth(int ways);
    return (ways > 1) ? $clog2(ways) : 1;
  endfunction

endpackage

// File: rtl/tagdir_ctrl.sv
module tagdir_ctrl
  import tagdir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flush,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       rspValid,
  output dirStrobe_t strobe
);

  assign reqReady      = !flush;
  assign strobe.lookup = reqValid && reqReady;
  assign strobe.clear  = flush;

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= strobe.lookup;
  end

  // R8
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  // R8
  rsp_needs_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady));

endmodule

// File: rtl/tagdir_datapath.sv
module tagdir_datapath
  import tagdir_pkg::*;
#(
  parameter int BLK_W   = 28,
  parameter int SETS    = 32,
  parameter int WAYS    = 2,
  parameter int IDX_W   = 5,
  parameter int TAG_W   = 23,
  parameter int WAY_W   = 1,
  parameter int SET_AW  = 5,
  parameter int STAMP_W = 32,
  parameter int CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dirStrobe_t       strobe,
  input  logic [BLK_W-1:0] blockAddr,
  output logic             rspHit,
  output logic [WAY_W-1:0] rspWay,
  output logic             rspEvictValid,
  output logic [TAG_W-1:0] rspEvictTag,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);

  logic [SET_AW-1:0] setIdx;
  logic [TAG_W-1:0]  reqTag;

  assign reqTag = blockAddr[BLK_W-1 -: TAG_W];

  generate
    if (IDX_W > 0) begin : g_indexed
      assign setIdx = blockAddr[IDX_W-1:0];
    end else begin : g_oneSet
      assign setIdx = '0;
    end
  endgenerate

  logic [WAYS-1:0]  validMem [SETS];
  logic [TAG_W-1:0] tagMem   [SETS][WAYS];

  logic [WAYS-1:0]  hitVec;
  logic             anyHit;
  logic             setFull;
  logic [WAY_W-1:0] hitWay, emptyWay, lruWay, fillWay, touchWay;

  always_comb begin
    hitWay   = '0;
    emptyWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      hitVec[w] = validMem[setIdx][w] && (tagMem[setIdx][w] == reqTag);
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!validMem[setIdx][w]) emptyWay = WAY_W'(w);
    end
  end

  assign anyHit   = |hitVec;
  assign setFull  = &validMem[setIdx];
  assign fillWay  = setFull ? lruWay : emptyWay;
  assign touchWay = anyHit ? hitWay : fillWay;

  // Replacement choice: absent for one way, age stamps otherwise
  generate
    if (WAYS == 1) begin : g_direct
      assign lruWay = '0;
    end else begin : g_lru
      logic [STAMP_W-1:0] stampMem [SETS][WAYS];
      logic [STAMP_W-1:0] useClock;
      logic [STAMP_W-1:0] oldest;

      always_comb begin
        lruWay = '0;
        oldest = stampMem[setIdx][0];
        for (int w = 1; w < WAYS; w++) begin
          if (stampMem[setIdx][w] < oldest) begin
            oldest = stampMem[setIdx][w];
            lruWay = WAY_W'(w);
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN)              useClock <= '0;
        else if (strobe.lookup) useClock <= useClock + 1'b1;
      end

      always_ff @(posedge clk) begin
        if (strobe.lookup) stampMem[setIdx][touchWay] <= useClock;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      for (int s = 0; s < SETS; s++) validMem[s] <= '0;
    end else if (strobe.lookup && !anyHit) begin
      validMem[setIdx][fillWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.lookup && !anyHit) tagMem[setIdx][fillWay] <= reqTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHit        <= 1'b0;
      rspWay        <= '0;
      rspEvictValid <= 1'b0;
      rspEvictTag   <= '0;
    end else if (strobe.lookup) begin
      rspHit        <= anyHit;
      rspWay        <= touchWay;
      rspEvictValid <= !anyHit && setFull;
      rspEvictTag   <= (!anyHit && setFull) ? tagMem[setIdx][fillWay] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      hitCount  <= '0;
      missCount <= '0;
    end else if (strobe.lookup) begin
      if (anyHit) hitCount  <= hitCount + 1'b1;
      else        missCount <= missCount + 1'b1;
    end
  end

  // R2
  single_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lookup |-> $onehot0(hitVec));

  // R3
  no_evict_on_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> !rspEvictValid);

  // R9
  hit_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookup && anyHit) |=> hitCount == $past(hitCount) + 1'b1);

  // R9
  miss_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookup && !anyHit) |=> missCount == $past(missCount) + 1'b1);

  // R10
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (hitCount == '0) && (missCount == '0));

endmodule

// File: rtl/setassoc_tagdir.sv
module setassoc_tagdir
  import tagdir_pkg::*;
#(
  parameter int CACHE_BYTES = 1024,
  parameter int LINE_BYTES  = 16,
  parameter int WAYS        = 2,
  parameter int ADDR_W      = 32,
  parameter int STAMP_W     = 32,
  parameter int CNT_W       = 32
) (
  input  logic                                                  clk,
  input  logic                                                  rstN,
  input  logic                                                  flush,
  input  logic                                                  reqValid,
  output logic                                                  reqReady,
  input  logic [ADDR_W-1:0]                                     reqAddr,
  output logic                                                  rspValid,
  output logic                                                  rspHit,
  output logic [wayWidth(WAYS)-1:0]                             rspWay,
  output logic                                                  rspEvictValid,
  output logic [tagWidth(ADDR_W,CACHE_BYTES,LINE_BYTES,WAYS)-1:0] rspEvictTag,
  output logic [CNT_W-1:0]                                      hitCount,
  output logic [CNT_W-1:0]                                      missCount
);

  localparam int SETS   = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W  = wayWidth(WAYS);
  localparam int SET_AW = (IDX_W > 0) ? IDX_W : 1;
  localparam int BLK_W  = ADDR_W - OFF_W;

  dirStrobe_t strobe;

  tagdir_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  tagdir_datapath #(
    .BLK_W   (BLK_W),
    .SETS    (SETS),
    .WAYS    (WAYS),
    .IDX_W   (IDX_W),
    .TAG_W   (TAG_W),
    .WAY_W   (WAY_W),
    .SET_AW  (SET_AW),
    .STAMP_W (STAMP_W),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .blockAddr     (reqAddr[ADDR_W-1:OFF_W]),
    .rspHit        (rspHit),
    .rspWay        (rspWay),
    .rspEvictValid (rspEvictValid),
    .rspEvictTag   (rspEvictTag),
    .hitCount      (hitCount),
    .missCount     (missCount)
  );

endmodule

// File: tb/setassoc_tagdir_tb.sv
`timescale 1ns/1ps
module setassoc_tagdir_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, flush, reqValid;
  logic [31:0] reqAddr;

  // two-way copy (32 sets, tag = addr >> 9)
  logic        rdy2, val2, hit2, ev2;
  logic [0:0]  way2;
  logic [22:0] tag2;
  logic [31:0] hc2, mc2;
  // direct-mapped copy (64 sets, tag = addr >> 10)
  logic        rdy1, val1, hit1, ev1;
  logic [0:0]  way1;
  logic [21:0] tag1;
  logic [31:0] hc1, mc1;
  // single-set copy (64 ways, tag = addr >> 4)
  logic        rdyF, valF, hitF, evF;
  logic [5:0]  wayF;
  logic [27:0] tagF;
  logic [31:0] hcF, mcF;

  setassoc_tagdir #(.WAYS(2)) u_dut (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid), .reqReady(rdy2),
    .reqAddr(reqAddr), .rspValid(val2), .rspHit(hit2), .rspWay(way2),
    .rspEvictValid(ev2), .rspEvictTag(tag2), .hitCount(hc2), .missCount(mc2));

  setassoc_tagdir #(.WAYS(1)) u_dm (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid), .reqReady(rdy1),
    .reqAddr(reqAddr), .rspValid(val1), .rspHit(hit1), .rspWay(way1),
    .rspEvictValid(ev1), .rspEvictTag(tag1), .hitCount(hc1), .missCount(mc1));

  setassoc_tagdir #(.WAYS(64)) u_fa (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid), .reqReady(rdyF),
    .reqAddr(reqAddr), .rspValid(valF), .rspHit(hitF), .rspWay(wayF),
    .rspEvictValid(evF), .rspEvictTag(tagF), .hitCount(hcF), .missCount(mcF));

  int checks = 0;
  int errors = 0;

  task automatic chkEq(input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // present one request; returns just after the accepting edge
  task automatic access(input logic [31:0] a);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush    = 1'b1;
    reqValid = 1'b1;
    reqAddr  = 32'h0;
    #1;
    chkEq("R8 reqReady low during flush", rdy2, 0);
    @(posedge clk);
    #1;
    chkEq("R10 request during flush not accepted", val2, 0);
    @(negedge clk);
    flush    = 1'b0;
    reqValid = 1'b0;
    chkEq("R10 hitCount cleared", hc2, 0);
    chkEq("R10 missCount cleared", mc2, 0);
  endtask

  task automatic testReset();
    chkEq("R11 rspValid low after reset", val2, 0);
    chkEq("R11 hitCount zero", hc2, 0);
    chkEq("R11 missCount zero", mc2, 0);
    chkEq("R8 reqReady high when idle", rdy2, 1);
    access(32'h0000_0040);
    chkEq("R11 first request misses", hit2, 0);
    chkEq("R11 no eviction from empty set", ev2, 0);
    chkEq("R8 rspValid after accept", val2, 1);
    idle();
    chkEq("R8 rspValid single pulse", val2, 0);
  endtask

  task automatic testThrash();
    doFlush();
    for (int i = 0; i < 6; i++) begin
      access((i % 2) ? 32'h0000_0400 : 32'h0000_0000);
      chkEq("R5 direct-mapped always misses", hit1, 0);
      chkEq("R5 eviction flag", ev1, (i >= 1) ? 1 : 0);
      if (i >= 1) chkEq("R1 R5 evicted tag is other address", tag1, (i % 2) ? 0 : 1);
      chkEq("R6 two-way hits after warm-up", hit2, (i >= 2) ? 1 : 0);
    end
    idle();
    chkEq("R9 direct-mapped misses", mc1, 6);
    chkEq("R9 direct-mapped hits", hc1, 0);
    chkEq("R9 two-way hits", hc2, 4);
    chkEq("R9 two-way misses", mc2, 2);
  endtask

  task automatic testOffset();
    doFlush();
    access(32'h0000_1230);
    chkEq("R2 first touch misses", hit2, 0);
    access(32'h0000_123F);
    chkEq("R2 same line other offset hits (2-way)", hit2, 1);
    chkEq("R2 same line other offset hits (1-way)", hit1, 1);
    chkEq("R2 same line other offset hits (1-set)", hitF, 1);
    chkEq("R2 hit reports way", way2, 0);
    access(32'h0000_1235);
    chkEq("R2 third offset hits", hit2, 1);
    access(32'h0000_1240);
    chkEq("R2 neighbour line misses", hit2, 0);
    idle();
  endtask

  task automatic testLru();
    doFlush();
    access(32'h0000_0000);
    chkEq("R3 fill lowest empty way", way2, 0);
    chkEq("R3 no eviction", ev2, 0);
    access(32'h0000_0200);
    chkEq("R3 second fill uses way 1", way2, 1);
    chkEq("R3 still no eviction", ev2, 0);
    access(32'h0000_0000);
    chkEq("R4 hit refreshes way 0", hit2, 1);
    access(32'h0000_0400);
    chkEq("R4 miss in full set", hit2, 0);
    chkEq("R4 victim is least recent way", way2, 1);
    chkEq("R4 eviction flagged", ev2, 1);
    chkEq("R1 R4 evicted tag", tag2, 1);
    access(32'h0000_0200);
    chkEq("R4 next victim way", way2, 0);
    chkEq("R4 next evicted tag", tag2, 0);
    access(32'h0000_0400);
    chkEq("R4 survivor still hits", hit2, 1);
    chkEq("R4 survivor way", way2, 1);
    idle();
  endtask

  task automatic testFull();
    doFlush();
    for (int i = 0; i < 64; i++) begin
      access(32'(i * 16));
      chkEq("R7 single set fill misses", hitF, 0);
      chkEq("R7 fill order", wayF, i);
      chkEq("R7 no eviction while filling", evF, 0);
    end
    access(32'h0000_0000);
    chkEq("R7 line 0 hits", hitF, 1);
    chkEq("R7 line 0 way", wayF, 0);
    access(32'h0000_0400);
    chkEq("R4 R7 full set evicts", evF, 1);
    chkEq("R4 R7 victim way is oldest", wayF, 1);
    chkEq("R1 R7 evicted tag", tagF, 1);
    idle();
    chkEq("R9 single set misses", mcF, 65);
    chkEq("R9 single set hits", hcF, 1);
    doFlush();
    access(32'h0000_0000);
    chkEq("R10 line misses after flush", hitF, 0);
    chkEq("R10 no eviction after flush", evF, 0);
    idle();
    chkEq("R10 counts restart", mcF, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN     = 1'b0;
    flush    = 1'b0;
    reqValid = 1'b0;
    reqAddr  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testThrash();
    testOffset();
    testLru();
    testFull();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule